// File: doc/BRIEF.md
# Serial Tuner Control Register

This block receives control words for a tuner frequency synthesizer over a three-wire link. The wires are an enable, a serial clock and a serial data line. The three wires are asynchronous to the block's system clock, so the block first synchronizes them and then looks for edges on the synchronized copies. While the enable is high, every falling edge of the serial clock shifts in one data bit and advances a bit counter. Each new rising edge of the enable clears that counter.

The number of bits received, and the moment the enable drops, decide which fields are loaded:

- **Band bits:** the four band-switch bits are loaded as soon as the fourth bit arrives.
- **19-bit word:** the divider pair (a 10-bit main count and a 5-bit swallow count) is loaded at the nineteenth falling edge.
- **18-bit word:** if the enable drops after exactly eighteen bits, and the length-select pin is low, the divider pair is loaded in short form instead.
- **27-bit word:** a word that runs to 27 bits also loads a group of test fields at its last edge. These are a three-bit test mode, two reference-divider select bits and a tuning-output disable bit.

A system that talks to the synthesizer drives the three wires from general-purpose outputs. The block's registered outputs feed the band drivers, the programmable divider, the reference divider and the tuning amplifier. The power-on state keeps the band outputs and the tuning output off until a divider word has been loaded.

Top module: `ser_synth_ctrl`

## Requirements
- R1: After reset: band_on = 0, m_div = 0, s_div = 0, mode19 = 1, test_sel = 3'b000, rs_a = 0, rs_b = 1 (the 1/1024 reference ratio) and tune_en = 0.
- R2: A bit is taken only on a falling edge of ser_clk while ser_en is high. Edges of ser_clk while ser_en is low change nothing. Every rising edge of ser_en starts the bit count again from zero.
- R3: Bits arrive in this order: band bits 3 down to 0, then the main count MSB first, then the swallow count bits 4 down to 0. band_on is loaded at the 4th falling edge and is visible before ser_en falls.
- R4: With len_open low, if ser_en falls after exactly 18 bits, the following are loaded: m_div = {0, bits 5..13}, s_div = bits 14..18 (bits counted from 1) and mode19 = 0.
- R5: At the 19th falling edge, the following are loaded without waiting for ser_en: m_div = bits 5..14, s_div = bits 15..19 and mode19 = 1. Later bits of the same word never change m_div or s_div.
- R6: A word that ends with fewer than 18 bits, or with fewer than 19 bits while len_open is high, changes nothing except band_on (and band_on only if at least 4 bits arrived).
- R7: At the 27th falling edge, bits 22..27 load test_sel[2], test_sel[1], test_sel[0], rs_a, rs_b and the tuning-disable bit, in that order. Bits 20 and 21 are don't-care. Words shorter than 27 bits leave these fields unchanged, and bits beyond the 27th are ignored.
- R8: tune_en is 1 only when a divider word has been loaded since reset and the last loaded tuning-disable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_en | input | 1 | Serial enable, high during a word |
| ser_clk | input | 1 | Serial clock; data taken on its falling edge |
| ser_dat | input | 1 | Serial data |
| len_open | input | 1 | Length select: low allows 18-bit words, high requires 19 |
| band_on | output | 4 | Band-switch outputs, bit 3 sent first |
| m_div | output | 10 | Main counter value |
| s_div | output | 5 | Swallow counter value |
| mode19 | output | 1 | 1 when the last divider load was a 19-bit word |
| test_sel | output | 3 | Test-mode selector |
| rs_a | output | 1 | Reference-divider select bit A |
| rs_b | output | 1 | Reference-divider select bit B |
| tune_en | output | 1 | Tuning output enable |

## Verification
The hardest cases to reach are the ones where the enable drops at exactly the count that matters. These are the 18-bit short load, and an 18-bit word while len_open is high, which must be discarded. A word that passes 19 or 27 bits must also leave the earlier fields alone. Random word lengths rarely land on 18, 19 or 27 by chance, so the stimulus picks lengths from a pool weighted toward 17, 18, 19, 26, 27 and 28, with random data and a random length-select pin. Directed words then probe the outputs in the middle of a transfer, after the 4th and the 19th bit. They also toggle the serial clock with the enable low before a full word is sent, to show the counter was not advanced.

// File: rtl/ser_synth_ctrl.sv
`timescale 1ns/1ps
module ser_synth_ctrl #(
  parameter int BAND_W = 4,
  parameter int M_W    = 10,
  parameter int S_W    = 5,
  parameter int TEST_W = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              len_open,
  output logic [BAND_W-1:0] band_on,
  output logic [M_W-1:0]    m_div,
  output logic [S_W-1:0]    s_div,
  output logic              mode19,
  output logic [2:0]        test_sel,
  output logic              rs_a,
  output logic              rs_b,
  output logic              tune_en
);
  localparam int LEN_LONG  = BAND_W + M_W + S_W;
  localparam int LEN_SHORT = LEN_LONG - 1;
  localparam int LEN_TEST  = LEN_LONG + TEST_W;
  localparam int SR_W      = LEN_TEST - 1;
  localparam int CNT_W     = $clog2(LEN_TEST + 1);
  localparam int TF_W      = 6;

  logic [SYNC-1:0]  en_p, ck_p, dt_p;
  logic             en_d, ck_d;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             os_q, loaded_q;

  wire en_s  = en_p[SYNC-1];
  wire ck_s  = ck_p[SYNC-1];
  wire dt_s  = dt_p[SYNC-1];
  wire en_rise = en_s & ~en_d;
  wire en_fall = ~en_s & en_d;
  wire shift   = en_s & en_d & ck_d & ~ck_s;
  wire at_end  = (cnt_q == CNT_W'(LEN_TEST));

  wire [LEN_LONG-1:0] w_long = {sr_q[LEN_LONG-2:0], dt_s};
  wire [TF_W-1:0]     w_test = {sr_q[TF_W-2:0], dt_s};

  assign tune_en = loaded_q & ~os_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p <= '0;
      ck_p <= '0;
      dt_p <= '0;
      en_d <= 1'b0;
      ck_d <= 1'b0;
    end else begin
      en_p <= {en_p[SYNC-2:0], ser_en};
      ck_p <= {ck_p[SYNC-2:0], ser_clk};
      dt_p <= {dt_p[SYNC-2:0], ser_dat};
      en_d <= en_s;
      ck_d <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (en_rise) begin
      cnt_q <= '0;
    end else if (shift && !at_end) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= {sr_q[SR_W-2:0], dt_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_on  <= '0;
      m_div    <= '0;
      s_div    <= '0;
      mode19   <= 1'b1;
      loaded_q <= 1'b0;
      test_sel <= 3'b000;
      rs_a     <= 1'b0;
      rs_b     <= 1'b1;
      os_q     <= 1'b0;
    end else begin
      if (shift && cnt_q == CNT_W'(BAND_W - 1))
        band_on <= {sr_q[BAND_W-2:0], dt_s};
      if (shift && cnt_q == CNT_W'(LEN_LONG - 1)) begin
        m_div    <= w_long[M_W+S_W-1:S_W];
        s_div    <= w_long[S_W-1:0];
        mode19   <= 1'b1;
        loaded_q <= 1'b1;
      end else if (en_fall && cnt_q == CNT_W'(LEN_SHORT) && !len_open) begin
        m_div    <= {1'b0, sr_q[M_W+S_W-2:S_W]};
        s_div    <= sr_q[S_W-1:0];
        mode19   <= 1'b0;
        loaded_q <= 1'b1;
      end
      if (shift && cnt_q == CNT_W'(LEN_TEST - 1)) begin
        test_sel <= w_test[5:3];
        rs_a     <= w_test[2];
        rs_b     <= w_test[1];
        os_q     <= w_test[0];
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LEN_TEST));
  p_band_at_fourth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (band_on != $past(band_on)) |-> (cnt_q == CNT_W'(BAND_W)));
  p_div_at_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_div != $past(m_div)) || (s_div != $past(s_div)))
      |-> (cnt_q == CNT_W'(LEN_SHORT) || cnt_q == CNT_W'(LEN_LONG)));
  p_short_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode19 |-> (m_div[M_W-1] == 1'b0));
  p_test_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((test_sel != $past(test_sel)) || (rs_a != $past(rs_a)) || (rs_b != $past(rs_b)))
      |-> (cnt_q == CNT_W'(LEN_TEST)));
  p_tune_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tune_en) |-> (cnt_q == CNT_W'(LEN_SHORT) || cnt_q == CNT_W'(LEN_LONG)
                        || cnt_q == CNT_W'(LEN_TEST)));
endmodule

// File: tb/sim_ser_synth_ctrl.sv
`timescale 1ns/1ps
module sim_ser_synth_ctrl;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, len_open = 1'b0;
  logic [3:0] band_on;
  logic [9:0] m_div;
  logic [4:0] s_div;
  logic mode19, rs_a, rs_b, tune_en;
  logic [2:0] test_sel;

  int checks = 0, errors = 0;

  logic [3:0] e_band;
  logic [9:0] e_m;
  logic [4:0] e_s;
  logic e_mode, e_rsa, e_rsb, e_os, e_loaded;
  logic [2:0] e_t;
  logic [0:29] q;
  int n;

  ser_synth_ctrl u0 (.clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .len_open(len_open), .band_on(band_on), .m_div(m_div),
    .s_div(s_div), .mode19(mode19), .test_sel(test_sel), .rs_a(rs_a), .rs_b(rs_b),
    .tune_en(tune_en));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int k);
    repeat (k * H) @(negedge clk);
  endtask

  task automatic check_all(input string ctx);
    chk({"R3 band ", ctx}, band_on, e_band);
    chk({"R5 m_div ", ctx}, m_div, e_m);
    chk({"R5 s_div ", ctx}, s_div, e_s);
    chk({"R4 mode19 ", ctx}, mode19, e_mode);
    chk({"R7 test_sel ", ctx}, test_sel, e_t);
    chk({"R7 rs_a ", ctx}, rs_a, e_rsa);
    chk({"R7 rs_b ", ctx}, rs_b, e_rsb);
    chk({"R8 tune_en ", ctx}, tune_en, e_loaded & ~e_os);
  endtask

  task automatic begin_word();
    n = 0;
    ser_en = 1'b1;
    wait_h(1);
  endtask

  task automatic clk_bit(input logic b);
    ser_dat = b;
    wait_h(1);
    ser_clk = 1'b1;
    wait_h(1);
    ser_clk = 1'b0;
    wait_h(1);
    if (n < 30) q[n] = b;
    n++;
    if (n == 4) e_band = {q[0], q[1], q[2], q[3]};
    if (n == 19) begin
      for (int i = 0; i < 10; i++) e_m[9-i] = q[4+i];
      for (int i = 0; i < 5; i++) e_s[4-i] = q[14+i];
      e_mode = 1'b1;
      e_loaded = 1'b1;
    end
    if (n == 27) begin
      e_t = {q[21], q[22], q[23]};
      e_rsa = q[24];
      e_rsb = q[25];
      e_os = q[26];
    end
  endtask

  task automatic end_word();
    ser_en = 1'b0;
    wait_h(2);
    if (n == 18 && !len_open) begin
      e_m[9] = 1'b0;
      for (int i = 0; i < 9; i++) e_m[8-i] = q[4+i];
      for (int i = 0; i < 5; i++) e_s[4-i] = q[13+i];
      e_mode = 1'b0;
      e_loaded = 1'b1;
    end
  endtask

  task automatic send_rand(input int len);
    begin_word();
    for (int i = 0; i < len; i++) clk_bit(1'($urandom));
    end_word();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    e_band = '0; e_m = '0; e_s = '0; e_mode = 1'b1; e_t = '0;
    e_rsa = 1'b0; e_rsb = 1'b1; e_os = 1'b0; e_loaded = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    chk("R1 tune_en off", tune_en, 0);
    chk("R1 rs_b", rs_b, 1);

    // R3 band visible mid-word, R4 short load on enable fall
    len_open = 1'b0;
    begin_word();
    clk_bit(1); clk_bit(0); clk_bit(1); clk_bit(1);
    chk("R3 band after 4th edge", band_on, 4'b1011);
    chk("R3 divider untouched mid-word", m_div, 0);
    for (int i = 0; i < 14; i++) clk_bit(1'(i % 3 == 0));
    chk("R4 no load before enable falls", mode19, 1);
    end_word();
    check_all("R4 short word");
    chk("R4 mode19 low", mode19, 0);
    chk("R8 tune on after load", tune_en, 1);

    // R2 clocks with enable low are ignored, counter restarts
    for (int i = 0; i < 10; i++) begin
      ser_dat = 1'($urandom); wait_h(1); ser_clk = 1'b1; wait_h(1); ser_clk = 1'b0; wait_h(1);
    end
    check_all("R2 clocks while idle");
    begin_word();
    for (int i = 0; i < 19; i++) clk_bit(1'(i % 2));
    // R5 loaded at 19th edge before enable falls
    chk("R5 m_div before enable fall", m_div, e_m);
    chk("R5 mode19 at 19th edge", mode19, 1);
    clk_bit(1); clk_bit(0); clk_bit(1);
    chk("R5 later bits ignored", s_div, e_s);
    end_word();
    check_all("R2 R5 long word");

    // R6 18 bits with length pin open: only band
    len_open = 1'b1;
    begin_word();
    for (int i = 0; i < 18; i++) clk_bit(1'(i < 4 ? (i == 1) : 1));
    end_word();
    check_all("R6 open 18");
    chk("R6 band updated", band_on, 4'b0100);
    len_open = 1'b0;
    send_rand(17);
    check_all("R6 17 bits");
    send_rand(2);
    check_all("R6 2 bits");

    // R7 test word, OS set then cleared; R8
    begin_word();
    for (int i = 0; i < 21; i++) clk_bit(1'(i % 5 == 0));
    clk_bit(1); clk_bit(0); clk_bit(1); clk_bit(1); clk_bit(0); clk_bit(1);
    chk("R7 test_sel", test_sel, 3'b101);
    chk("R8 tune off when OS=1", tune_en, 0);
    clk_bit(0); clk_bit(0); clk_bit(0);
    end_word();
    check_all("R7 past 27 ignored");
    send_rand(27);
    check_all("R7 random test word");

    for (int t = 0; t < 80; t++) begin
      int pick;
      int len;
      pick = $urandom_range(0, 9);
      case (pick)
        0: len = 17; 1: len = 18; 2: len = 19; 3: len = 26; 4: len = 27; 5: len = 28;
        default: len = $urandom_range(0, 30);
      endcase
      len_open = 1'($urandom);
      send_rand(len);
      check_all("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule